// File: doc/BRIEF.md
# Strip-Mined Strided Vector Address Generator

This block turns one vector memory operation of any total element count into a sequence of strips, none longer than the vector register length (64 elements by default). For every strip it publishes the strip's length value and streams one memory address per element. Each address is the latched base plus the element's running index times a signed stride. Unit stride walks consecutive words, while other strides step along a row or a column of a stored matrix.

The short remainder strip comes first, and every strip after it is full length. Because the running address simply keeps stepping by the stride, each new strip starts at the previous strip's start plus its length times the stride. A consumer takes addresses with a valid/ready handshake. An element is consumed only on a cycle where both are high. The element flagged last closes its strip, and a pulse marks the end of the whole operation.

The controller has three states. `ST_IDLE` waits for `start_i`. `ST_EMIT` streams addresses. `ST_FINISH` raises the completion pulse for one cycle. Its transitions are:

- `ST_IDLE` to `ST_EMIT` on start with a nonzero count.
- `ST_IDLE` to `ST_FINISH` on start with a zero count.
- `ST_EMIT` to `ST_EMIT` on the last handshake of a strip while elements remain, which loads a full strip.
- `ST_EMIT` to `ST_FINISH` on the last handshake of the final strip.
- `ST_FINISH` to `ST_IDLE` unconditionally.

Top module: `strip_addr_gen`

## Requirements
- R1: After reset, `valid_o`, `last_o`, `strip_done_o` and `all_done_o` are low and `vl_o` is 0.
- R2: The first strip holds N mod 64 elements, or 64 when that remainder is 0. Every later strip holds 64. While a strip is streaming, `vl_o` equals its length. The number of strips is ceil(N/64); for N = 200 the strips are 8, 64, 64, 64.
- R3: No strip of zero length is ever produced, and exactly N elements are emitted in total.
- R4: The address of global element g (counted from 0 across all strips) is (base + g × stride) mod 2^24. The stride is a 24-bit two's-complement value, so 24'hFFFFFE steps by −2.
- R5: The stream advances only on a cycle with `valid_o` and `ready_i` both high. While `valid_o` is high and `ready_i` is low, the address, last flag and `vl_o` hold their values into the next cycle.
- R6: `last_o` is high exactly on the final element of each strip. `strip_done_o` is high exactly on the cycle when that element is accepted (`valid_o`, `ready_i` and `last_o` all high).
- R7: `all_done_o` pulses high for exactly one cycle, in the cycle after the final element is accepted, and no address is valid at that time.
- R8: With N = 0, `all_done_o` pulses in the cycle after `start_i` and no address is ever presented.
- R9: `start_i` is ignored unless the block is idle. A start during streaming changes neither the addresses nor the strip lengths of the running operation. N, base and stride are captured on the accepted start, so later changes on those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| total_len_i | input | 16 | Total element count N |
| base_i | input | 24 | Address of element 0 |
| stride_i | input | 24 | Signed element stride |
| ready_i | input | 1 | Consumer accepts the current address |
| addr_o | output | 24 | Current element address |
| valid_o | output | 1 | `addr_o` holds a live element |
| last_o | output | 1 | Current element closes its strip |
| vl_o | output | 7 | Length of the current strip |
| strip_done_o | output | 1 | Final element of a strip accepted this cycle |
| all_done_o | output | 1 | One-cycle pulse: operation finished |

## Verification
A corrupted element counter or strip-length register shows up at the ports within one strip. It appears as `last_o` landing on the wrong element, a `vl_o` value other than the expected remainder or 64, or a wrong number of elements before `all_done_o`. A corrupted address accumulator or captured stride yields a wrong `addr_o` on the very next accepted element, so every handshake is compared with base + g × stride. A faulty remaining-count register or state machine changes the cycle on which `all_done_o` fires relative to the final handshake, and the bench checks that cycle exactly.

// File: rtl/vag_pkg.sv
package vag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_FINISH = 2'd2
    } vag_state_e;
endpackage

// File: rtl/vag_strip_sizer.sv
// Length of the leading (remainder) strip: total mod MAXVL, or MAXVL when
// the remainder is zero, so that no empty strip is ever planned.
module vag_strip_sizer #(
    parameter int LEN_W = 16,
    parameter int MAXVL = 64,
    parameter int VL_W  = $clog2(MAXVL + 1)
) (
    input  logic [LEN_W-1:0] total_i,
    output logic [VL_W-1:0]  first_len_o
);
    localparam bit IS_POW2 = ((MAXVL & (MAXVL - 1)) == 0);

    generate
        if (IS_POW2) begin : g_mask
            localparam int MW = $clog2(MAXVL);
            logic [MW-1:0] rem;
            assign rem = total_i[MW-1:0];
            assign first_len_o = (rem == '0) ? VL_W'(MAXVL) : VL_W'(rem);
        end else begin : g_mod
            logic [LEN_W-1:0] rem;
            assign rem = total_i % LEN_W'(MAXVL);
            assign first_len_o = (rem == '0) ? VL_W'(MAXVL) : VL_W'(rem);
        end
    endgenerate
endmodule

// File: rtl/vag_addr_accum.sv
// Running element address: loaded with the base, stepped by the signed
// stride on every accepted element; wraps modulo 2^ADDR_W.
module vag_addr_accum #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] stride_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (load_i) begin
            addr_o <= load_val_i;
        end else if (step_i) begin
            addr_o <= addr_o + stride_i;
        end
    end
endmodule

// File: rtl/vag_elem_counter.sv
// Position of the current element inside its strip.
module vag_elem_counter #(
    parameter int VL_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            step_i,
    output logic [VL_W-1:0] idx_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (clear_i) begin
            idx_o <= '0;
        end else if (step_i) begin
            idx_o <= idx_o + 1'b1;
        end
    end
endmodule

// File: rtl/strip_addr_gen.sv
module strip_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    parameter int MAXVL  = 64,
    parameter int VL_W   = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  total_len_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic              ready_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              last_o,
    output logic [VL_W-1:0]   vl_o,
    output logic              strip_done_o,
    output logic              all_done_o
);
    import vag_pkg::*;

    localparam logic [VL_W-1:0]  FULL_VL  = VL_W'(MAXVL);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAXVL);

    vag_state_e        state_q, state_d;
    logic [LEN_W-1:0]  remain_q;
    logic [VL_W-1:0]   vl_q;
    logic [ADDR_W-1:0] stride_q;
    logic [VL_W-1:0]   idx;
    logic [VL_W-1:0]   first_len;

    logic accept, fire, at_last, strip_end, final_end, next_strip;

    assign accept     = (state_q == ST_IDLE) && start_i;
    assign fire       = (state_q == ST_EMIT) && ready_i;
    assign at_last    = (idx == vl_q - 1'b1);
    assign strip_end  = fire && at_last;
    assign final_end  = strip_end && (remain_q == '0);
    assign next_strip = strip_end && (remain_q != '0);

    vag_strip_sizer #(.LEN_W(LEN_W), .MAXVL(MAXVL), .VL_W(VL_W)) u_sizer (
        .total_i     (total_len_i),
        .first_len_o (first_len)
    );

    vag_addr_accum #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (base_i),
        .step_i     (fire),
        .stride_i   (stride_q),
        .addr_o     (addr_o)
    );

    vag_elem_counter #(.VL_W(VL_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept || strip_end),
        .step_i  (fire),
        .idx_o   (idx)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = (total_len_i == '0) ? ST_FINISH : ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (final_end) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Strip bookkeeping: length of current strip and elements beyond it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            vl_q     <= '0;
            stride_q <= '0;
        end else if (accept) begin
            stride_q <= stride_i;
            if (total_len_i == '0) begin
                remain_q <= '0;
                vl_q     <= '0;
            end else begin
                remain_q <= total_len_i - LEN_W'(first_len);
                vl_q     <= first_len;
            end
        end else if (next_strip) begin
            remain_q <= remain_q - FULL_LEN;
            vl_q     <= FULL_VL;
        end
    end

    // Outputs
    always_comb begin
        valid_o      = 1'b0;
        last_o       = 1'b0;
        strip_done_o = 1'b0;
        all_done_o   = 1'b0;
        vl_o         = vl_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_EMIT: begin
                valid_o      = 1'b1;
                last_o       = at_last;
                strip_done_o = strip_end;
            end
            ST_FINISH: all_done_o = 1'b1;
            default: ;
        endcase
    end

    // Assertions
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !valid_o && !all_done_o && !strip_done_o);

    a_r2_vl_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (vl_o != '0) && (vl_o <= FULL_VL));

    a_r2_later_strip_full: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_done_o && remain_q != '0) |=> valid_o && (vl_o == FULL_VL));

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !(last_o && remain_q == '0))
        |=> valid_o && (addr_o == $past(addr_o) + $past(stride_q)));

    a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i)
        |=> valid_o && $stable(addr_o) && $stable(last_o) && $stable(vl_o));

    a_r6_strip_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        strip_done_o |-> valid_o && ready_i && last_o);

    a_r7_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && last_o && remain_q == '0) |=> all_done_o && !valid_o);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        all_done_o |=> !all_done_o && !valid_o);

    a_r8_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && total_len_i == '0) |=> all_done_o && !valid_o);
endmodule

// File: tb/tb_strip_addr_gen.sv
`timescale 1ns/1ps
module tb_strip_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] total_len_i = '0;
    logic [23:0] base_i = '0;
    logic [23:0] stride_i = '0;
    logic        ready_i = 1'b0;
    logic [23:0] addr_o;
    logic        valid_o, last_o, strip_done_o, all_done_o;
    logic [6:0]  vl_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    strip_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_len_i(total_len_i),
        .base_i(base_i), .stride_i(stride_i), .ready_i(ready_i),
        .addr_o(addr_o), .valid_o(valid_o), .last_o(last_o), .vl_o(vl_o),
        .strip_done_o(strip_done_o), .all_done_o(all_done_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One full operation; rmode 0 = always ready, 1 = ready 2 of every 3 cycles.
    // poke > 0 raises a stray start with other parameters on that cycle.
    task automatic run_case(input int n, input logic [23:0] base,
                            input logic [23:0] stride, input int rmode,
                            input int poke);
        int g = 0, loc = 0, strips = 0, fin_cyc = -1, cur_len, exp_strips;
        logic [23:0] ea = base;
        logic [23:0] stall_addr = '0;
        bit stalled = 1'b0, fin = 1'b0, exp_last;
        cur_len    = (n % 64 == 0) ? 64 : n % 64;
        exp_strips = (n + 63) / 64;
        if (n == 0) fin_cyc = 0;
        @(negedge clk);
        total_len_i = 16'(n); base_i = base; stride_i = stride; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        total_len_i = 16'd3; base_i = 24'h555555; stride_i = 24'd9; // R9 latched inputs
        for (int cyc = 1; cyc < 3000 && !fin; cyc++) begin
            if (cyc > 1) @(negedge clk);
            start_i = (cyc == poke);
            if (cyc == poke) begin
                total_len_i = 16'd5; base_i = 24'h123456; stride_i = 24'd77;
            end
            ready_i = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
            #1;
            if (stalled)
                chk(valid_o && addr_o == stall_addr, "R5 stall hold", addr_o, stall_addr);
            if (valid_o) begin
                exp_last = (loc == cur_len - 1);
                chk(addr_o == ea, "R4 address", addr_o, ea);
                chk(last_o == exp_last, "R6 last flag", last_o, exp_last);
                chk(vl_o == 7'(cur_len), "R2 strip VL", vl_o, cur_len);
                chk(strip_done_o == (ready_i && exp_last), "R6 strip_done",
                    strip_done_o, ready_i && exp_last);
                chk(g < n, "R3 element count bound", g, n);
                if (ready_i) begin
                    g++;
                    ea = ea + stride;
                    if (exp_last) begin
                        strips++;
                        loc = 0;
                        cur_len = 64;
                        if (g == n) fin_cyc = cyc;
                    end else begin
                        loc++;
                    end
                end
                stalled = !ready_i;
                stall_addr = addr_o;
            end else begin
                stalled = 1'b0;
                chk(!strip_done_o, "R6 strip_done idle", strip_done_o, 0);
            end
            if (all_done_o) begin
                chk(cyc == fin_cyc + 1, "R7 done timing", cyc, fin_cyc + 1);
                chk(!valid_o, "R7 no valid at done", valid_o, 0);
                fin = 1'b1;
            end
        end
        start_i = 1'b0;
        chk(fin, "R7 all_done seen", fin, 1);
        chk(g == n, "R3 total elements", g, n);
        chk(strips == exp_strips, "R2 strip count", strips, exp_strips);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); #1;
            chk(!valid_o && !all_done_o, "R7 single pulse", {valid_o, all_done_o}, 0);
        end
    endtask

    task automatic test_reset();
        #1;
        chk(!valid_o && !last_o && !strip_done_o && !all_done_o, "R1 reset flags",
            {valid_o, last_o, strip_done_o, all_done_o}, 0);
        chk(vl_o == 0, "R1 reset VL", vl_o, 0);
    endtask

    task automatic test_n200();   run_case(200, 24'h000100, 24'd3, 0, 0); endtask   // R2 8,64,64,64
    task automatic test_exact();  run_case(128, 24'h000000, 24'd1, 0, 0);           // R3 no empty strip
                                  run_case(64, 24'h000040, 24'd2, 0, 0); endtask
    task automatic test_single(); run_case(1, 24'hFFFFFF, 24'd5, 0, 0); endtask     // R4 wrap
    task automatic test_negative_bp(); run_case(70, 24'h000005, 24'hFFFFFE, 1, 0); endtask // R4 R5
    task automatic test_empty();  run_case(0, 24'h000010, 24'd4, 0, 0); endtask      // R8
    task automatic test_busy_start(); run_case(100, 24'h00A000, 24'd7, 1, 20); endtask // R9
    task automatic test_65_bp();  run_case(65, 24'hFFFFF0, 24'd16, 1, 0); endtask    // R2 R5

    initial begin
        ready_i = 1'b0;
        #1;
        test_reset();
        #10 rst_n = 1'b1;
        test_n200();
        test_exact();
        test_single();
        test_negative_bp();
        test_empty();
        test_busy_start();
        test_65_bp();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule